// File: doc/BRIEF.md
# Four-Bit Sliced ALU with Condition Flags

This block is a purely combinational arithmetic and logic unit. It is built as a ripple chain of identical one-bit slices, with a flag unit at its upper end. Each slice can invert its A bit and its B bit. It forms the AND, the OR and the full-adder sum of the two bits, and passes its carry to the slice above it.

Four control lines steer the whole chain: an A-inversion line, a B-negation line and a two-bit operation select. The B-negation line also supplies the carry into the lowest slice, so a subtraction is an add of the inverted B plus one.

Next to the result, the unit reports six flags: zero, sign, carry, signed overflow, a signed less-than and an equality. The less-than flag corrects the sign of a difference for signed overflow, so it stays right for every operand pair. The equality flag reuses the zero detector and needs no comparator of its own. The operand width is a parameter, and the default is four bits.

Top module: `alu4_flags`

## Requirements
- R1: With op_sel = 2'b00 the result is the bitwise AND of the effective operands. The effective A is ~a when inv_a = 1, and the effective B is ~b when neg_b = 1. With inv_a = neg_b = 1 this gives NOR of a and b.
- R2: With op_sel = 2'b01 the result is the bitwise OR of the effective operands. With inv_a = neg_b = 1 this gives NAND of a and b.
- R3: With op_sel = 2'b10 the result is the effective A plus the effective B plus neg_b, modulo 2^WIDTH. Control {inv_a, neg_b, op_sel} = 4'b0010 yields a + b.
- R4: Control 4'b0110 yields a - b modulo 2^WIDTH, because neg_b both inverts b and drives the lowest slice's carry-in.
- R5: With op_sel = 2'b11 the result is all zeros.
- R6: flag_z is 1 exactly when every result bit is 0.
- R7: flag_s equals the top bit of the result.
- R8: flag_c is the carry out of the top slice of the adder chain. That is bit WIDTH of (effective A + effective B + neg_b), whatever op_sel is.
- R9: flag_v is 1 exactly when that adder-chain sum overflows as a signed two's-complement value.
- R10: Under control 4'b0110, flag_lt is 1 exactly when a < b as signed values, for all 256 pairs, overflowing ones included.
- R11: Under control 4'b0110, flag_eq is 1 exactly when a equals b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inv_a | input | 1 | Invert every A bit |
| neg_b | input | 1 | Invert every B bit and set the lowest carry-in |
| op_sel | input | 2 | 00 AND, 01 OR, 10 add, 11 zero |
| a | input | 4 | Operand A |
| b | input | 4 | Operand B |
| result | output | 4 | Operation result |
| flag_z | output | 1 | Result is zero |
| flag_s | output | 1 | Result sign bit |
| flag_c | output | 1 | Carry out of top slice |
| flag_v | output | 1 | Signed overflow |
| flag_lt | output | 1 | Signed A < B (valid after subtract) |
| flag_eq | output | 1 | A equals B (valid after subtract) |

## Verification
The assertions run on every input change. They tie the add and subtract results, the carry out, the all-zero reserved operation, and the less-than and equality flags directly to the operands.

Only the bench's scenarios cover the logic operations under every inversion combination. The same holds for the zero, sign and overflow flags in all sixteen control words. The bench also sweeps all operand pairs in each control word, which shows that the overflow correction is right at the boundary pairs such as -8 against 1 and 7 against -1.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
    typedef enum logic [1:0] {
        OP_AND  = 2'b00,
        OP_OR   = 2'b01,
        OP_ADD  = 2'b10,
        OP_ZERO = 2'b11
    } op_e;

    typedef struct packed {
        logic z;
        logic s;
        logic c;
        logic v;
        logic lt;
        logic eq;
    } flags_t;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu4_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       inv_a_i,
    input  logic       inv_b_i,
    input  logic       cin_i,
    input  logic [1:0] op_i,
    output logic       r_o,
    output logic       cout_o
);
    logic a_eff, b_eff, sum_bit;

    always_comb begin
        a_eff   = inv_a_i ? ~a_i : a_i;
        b_eff   = inv_b_i ? ~b_i : b_i;
        sum_bit = a_eff ^ b_eff ^ cin_i;
        cout_o  = (a_eff & b_eff) | (cin_i & (a_eff | b_eff));
        case (op_e'(op_i))
            OP_AND:  r_o = a_eff & b_eff;
            OP_OR:   r_o = a_eff | b_eff;
            OP_ADD:  r_o = sum_bit;
            default: r_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu4_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] res_i,
    input  logic             cin_msb_i,
    input  logic             cout_msb_i,
    output flags_t           flags_o
);
    localparam int MSB = WIDTH - 1;

    flags_t flags_d;

    always_comb begin
        flags_d.z  = ~|res_i;
        flags_d.s  = res_i[MSB];
        flags_d.c  = cout_msb_i;
        flags_d.v  = cin_msb_i ^ cout_msb_i;
        flags_d.lt = flags_d.s ^ flags_d.v;
        flags_d.eq = flags_d.z;
        flags_o    = flags_d;
    end
endmodule

// File: rtl/alu4_flags.sv
module alu4_flags
    import alu4_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             inv_a,
    input  logic             neg_b,
    input  logic [1:0]       op_sel,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] result,
    output logic             flag_z,
    output logic             flag_s,
    output logic             flag_c,
    output logic             flag_v,
    output logic             flag_lt,
    output logic             flag_eq
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   carry_d;
    logic [WIDTH-1:0] res_d;
    flags_t           flags_d;

    assign carry_d[0] = neg_b;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_bit_slice u_slice (
            .a_i     (a[i]),
            .b_i     (b[i]),
            .inv_a_i (inv_a),
            .inv_b_i (neg_b),
            .cin_i   (carry_d[i]),
            .op_i    (op_sel),
            .r_o     (res_d[i]),
            .cout_o  (carry_d[i+1])
        );
    end

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .res_i      (res_d),
        .cin_msb_i  (carry_d[MSB]),
        .cout_msb_i (carry_d[WIDTH]),
        .flags_o    (flags_d)
    );

    always_comb begin
        result  = res_d;
        flag_z  = flags_d.z;
        flag_s  = flags_d.s;
        flag_c  = flags_d.c;
        flag_v  = flags_d.v;
        flag_lt = flags_d.lt;
        flag_eq = flags_d.eq;
    end
endmodule

// File: rtl/alu4_flags_chk.sv
module alu4_flags_chk #(
    parameter int WIDTH = 4
) (
    input logic             inv_a,
    input logic             neg_b,
    input logic [1:0]       op_sel,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [WIDTH-1:0] result,
    input logic             flag_z,
    input logic             flag_s,
    input logic             flag_c,
    input logic             flag_v,
    input logic             flag_lt,
    input logic             flag_eq
);
    logic [WIDTH:0] add_wide;
    logic           is_add, is_sub;

    always_comb begin
        add_wide = {1'b0, a} + {1'b0, b};
        is_add   = ({inv_a, neg_b, op_sel} == 4'b0010);
        is_sub   = ({inv_a, neg_b, op_sel} == 4'b0110);
        if (is_add) begin
            a_r3_add_sum: assert (result == add_wide[WIDTH-1:0]);
            a_r8_add_carry: assert (flag_c == add_wide[WIDTH]);
        end
        if (is_sub) begin
            a_r4_sub_diff: assert (result == WIDTH'(a - b));
            a_r10_signed_lt: assert (flag_lt == ($signed(a) < $signed(b)));
            a_r11_equal: assert (flag_eq == (a == b));
        end
        if (op_sel == 2'b11) begin
            a_r5_zero_op: assert (result == '0 && flag_z);
        end
    end
endmodule

bind alu4_flags alu4_flags_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu4_flags_test.sv
module alu4_flags_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inv_a = 1'b0, neg_b = 1'b0;
    logic [1:0] op_sel = 2'b00;
    logic [3:0] a = 4'd0, b = 4'd0;
    logic [3:0] result;
    logic       flag_z, flag_s, flag_c, flag_v, flag_lt, flag_eq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [3:0] ctrl;
        logic [3:0] a, b, r;
        logic z, s, c, v, lt, eq;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    alu4_flags uut (
        .inv_a(inv_a), .neg_b(neg_b), .op_sel(op_sel), .a(a), .b(b),
        .result(result), .flag_z(flag_z), .flag_s(flag_s), .flag_c(flag_c),
        .flag_v(flag_v), .flag_lt(flag_lt), .flag_eq(flag_eq)
    );

    function automatic item_t model(logic [3:0] ctrl, logic [3:0] xa, logic [3:0] xb);
        item_t it;
        logic [3:0] ea, eb;
        logic [4:0] sum;
        int sa, sb_v, ss;
        ea = ctrl[3] ? ~xa : xa;
        eb = ctrl[2] ? ~xb : xb;
        sum = {1'b0, ea} + {1'b0, eb} + {4'd0, ctrl[2]};
        case (ctrl[1:0])
            2'b00: it.r = ea & eb;
            2'b01: it.r = ea | eb;
            2'b10: it.r = sum[3:0];
            default: it.r = 4'd0;
        endcase
        sa = $signed(ea); sb_v = $signed(eb);
        ss = sa + sb_v + int'(ctrl[2]);
        it.ctrl = ctrl; it.a = xa; it.b = xb;
        it.z = (it.r == 4'd0);
        it.s = it.r[3];
        it.c = sum[4];
        it.v = (ss > 7) || (ss < -8);
        it.lt = ($signed(xa) < $signed(xb));
        it.eq = (xa == xb);
        return it;
    endfunction

    function automatic string res_tag(logic [3:0] ctrl);
        case (ctrl[1:0])
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return (ctrl == 4'b0110) ? "R4" : "R3";
            default: return "R5";
        endcase
    endfunction

    task automatic cmp(string tag, item_t it, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s ctrl=%b a=%h b=%h actual=%b expected=%b",
                     tag, it.ctrl, it.a, it.b, act, exp);
        end
    endtask

    task automatic drive(logic [3:0] ctrl, logic [3:0] xa, logic [3:0] xb);
        @(posedge clk);
        {inv_a, neg_b, op_sel} = ctrl;
        a = xa;
        b = xb;
        sb.push_back(model(ctrl, xa, xb));
    endtask

    // Monitor: compare at the falling edge after each drive
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (result !== it.r) begin
                    errors++;
                    $display("FAIL %s ctrl=%b a=%h b=%h actual=%h expected=%h",
                             res_tag(it.ctrl), it.ctrl, it.a, it.b, result, it.r);
                end
                cmp("R6", it, flag_z, it.z);
                cmp("R7", it, flag_s, it.s);
                cmp("R8", it, flag_c, it.c);
                cmp("R9", it, flag_v, it.v);
                if (it.ctrl == 4'b0110) begin
                    cmp("R10", it, flag_lt, it.lt);
                    cmp("R11", it, flag_eq, it.eq);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state with zero inputs: add of zeros gives zero result and zero flag (R3, R6)
        drive(4'b0010, 4'd0, 4'd0);
        // boundary subtract pairs where the raw sign is wrong (R10)
        drive(4'b0110, 4'h8, 4'h1);
        drive(4'b0110, 4'h7, 4'hF);
        // exhaustive sweep: every control word, every operand pair (R1..R11 via tags)
        for (int c = 0; c < 16; c++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    drive(4'(c), 4'(i), 4'(j));
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule